// File: doc/BRIEF.md
# Processor Limit Counter Timer

This block is a per-processor counter/timer sitting on a small 32-bit word-addressed register bus. It has two personalities, chosen by an input driven by a system-level controller. In limit mode, a count advances one unit per 500 ns tick. The unit is weighted at bit 9 of the register view, so the nine low bits always read zero. When the count arrives at a programmable limit, the block latches a reached flag and raises its interrupt. It then folds back to zero on the following tick, so the interrupt recurs periodically. Software acknowledges the event by reading the limit word.

In user mode the same counter widens to a 63-bit free-running value with no limit and no interrupt. Software can start it, stop it, restart it from zero, and read it as two 32-bit halves.

A change of the mode input restarts the counter under the new personality with a clean state. Interrupt routing and bus bridging live outside the block.

Top module: `proc_limit_timer`

## Requirements
- R1: After reset the count is zero, the reached flag and the interrupt are low, the counter is running (word 3 reads 1), and the limit is the largest value (word 0 reads 0x7FFFFE00 in limit mode).
- R2: Each tick while running and not restarted advances the count by one unit of weight 2^9. Bits 8:0 of every count or limit readout are zero.
- R3: In limit mode, the tick that brings the count equal to the limit sets the reached flag (word 1 bit 31) and raises the interrupt on the clock edge of that tick. The next tick returns the count to zero and counting continues.
- R4: In limit mode, reading word 0 returns the limit in bits 30:9 with bit 31 zero. At that clock edge the read clears the reached flag and the interrupt. If a limit hit occurs on the same edge, the hit wins.
- R5: In limit mode, a write to word 0 sets the limit from write-data bits 30:9, restarts the count at zero, and lowers the interrupt, leaving the reached flag unchanged. A write to word 2 sets the limit the same way without disturbing the count. A restart coinciding with a tick takes precedence over the tick.
- R6: A written limit whose bits 30:9 are all zero is stored as the largest value (all ones in bits 30:9).
- R7: In user mode the reached flag and the interrupt never rise. Word 0 reads bits 62:32 of the 63-bit count value, with bit 31 zero. Word 1 reads bits 31:0, with bits 8:0 zero.
- R8: In user mode, a write to word 0 or word 1, whatever the data, restarts the count at zero.
- R9: In user mode, write-data bit 0 of a word 3 write starts (1) or stops (0) the counter. A stopped counter ignores ticks. Word 3 reads the running status in bit 0 in either mode. A word 3 write in limit mode has no effect.
- R10: A change of the `user_mode` input takes effect one clock later. It restarts the count at zero, clears the reached flag and the interrupt, sets the counter running, and restores the largest limit.
- R11: Reads of word 2 and of words 4 and above return zero. Writes to words 4 and above have no effect. So do a word 1 write in limit mode and a word 2 write in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| tick | input | 1 | One-cycle pulse every 500 ns that advances the count |
| user_mode | input | 1 | 1 selects the free-running user counter, 0 selects limit mode |
| bus_addr | input | ADDR_W (3) | Word index of the register access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; valid in the cycle `bus_rd` is high, zero otherwise |
| irq | output | 1 | Level interrupt, raised on a limit hit |

## Verification
The assertions assume that `tick` is a single-cycle pulse in the clock domain, that `bus_rd` and `bus_wr` are never high together, and that `user_mode` is synchronous and held for at least two cycles. They also assume that reads and writes do not rely on a mode change in the very cycle the change is registered. The bench drives every input on the falling clock edge and issues one bus access at a time with an idle cycle between accesses. It changes `user_mode` only between accesses and then waits two cycles. Where the design must resolve coincident events, the bench drives `tick` together with a bus strobe on purpose.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  // register view: a count unit is weighted at bit UNIT_LSB
  localparam int DATA_W   = 32;
  localparam int UNIT_LSB = 9;
  localparam int LIM_W    = DATA_W - 1 - UNIT_LSB;   // limit field, bits 30:9
  localparam int WIDE_W   = 63;                      // user value width
  localparam int USR_W    = WIDE_W - UNIT_LSB;       // user count width
  localparam int LO_W     = DATA_W - UNIT_LSB;       // count bits in low word
  localparam int HI_W     = USR_W - LO_W;            // count bits in high word

  // word indices, decoded by software
  localparam int WORD_LIMIT  = 0;
  localparam int WORD_COUNT  = 1;
  localparam int WORD_LIMNR  = 2;
  localparam int WORD_RUN    = 3;

  typedef struct packed {
    logic rd_clear;     // limit read acknowledges the event
    logic ld_limit;     // new limit from the bus
    logic bus_restart;  // bus asks for a count restart
    logic run_wr;       // start/stop write in user mode
  } strobe_t;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_LIMIT,
    RS_SYSCNT,
    RS_USRHI,
    RS_USRLO,
    RS_RUN
  } rsel_e;
endpackage

// File: rtl/ptmr_rst_sync.sv
module ptmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ptmr_decode.sv
module ptmr_decode
  import ptmr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              user,
  output strobe_t           strobe,
  output rsel_e             rsel
);
  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(WORD_LIMIT);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(WORD_COUNT);
  localparam logic [ADDR_W-1:0] A_LIMNR = ADDR_W'(WORD_LIMNR);
  localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(WORD_RUN);

  logic hit_limit, hit_count, hit_limnr, hit_run;

  always_comb begin
    hit_limit = (bus_addr == A_LIMIT);
    hit_count = (bus_addr == A_COUNT);
    hit_limnr = (bus_addr == A_LIMNR);
    hit_run   = (bus_addr == A_RUN);
  end

  // side-effect strobes
  always_comb begin
    strobe             = '0;
    strobe.rd_clear    = bus_rd & hit_limit & ~user;
    strobe.ld_limit    = bus_wr & ~user & (hit_limit | hit_limnr);
    strobe.bus_restart = bus_wr & (user ? (hit_limit | hit_count) : hit_limit);
    strobe.run_wr      = bus_wr & user & hit_run;
  end

  // read source selection
  always_comb begin
    rsel = RS_ZERO;
    if (bus_rd) begin
      if (hit_limit)      rsel = user ? RS_USRHI : RS_LIMIT;
      else if (hit_count) rsel = user ? RS_USRLO : RS_SYSCNT;
      else if (hit_run)   rsel = RS_RUN;
      else                rsel = RS_ZERO;
    end
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_en,
  input  logic             user,
  input  logic             restart,
  input  logic             mode_chg,
  input  logic             ld_limit,
  input  logic [LIM_W-1:0] lim_wr,
  output logic [USR_W-1:0] cnt,
  output logic [LIM_W-1:0] limit,
  output logic             hit
);
  logic [USR_W-1:0] cnt_q, cnt_d;
  logic [LIM_W-1:0] lim_q, lim_d;
  logic [USR_W-1:0] lim_ext, inc_sys, inc_usr;
  logic             step, at_lim;

  always_comb begin
    lim_ext = {{(USR_W-LIM_W){1'b0}}, lim_q};
    step    = tick & run_en & ~restart;
    at_lim  = ~user & (cnt_q == lim_ext);
    inc_sys = {{(USR_W-LIM_W){1'b0}}, cnt_q[LIM_W-1:0] + 1'b1};
    inc_usr = cnt_q + 1'b1;
    hit     = step & ~user & ~at_lim & (inc_sys == lim_ext);
  end

  // count next state
  always_comb begin
    cnt_d = cnt_q;
    if (restart)      cnt_d = '0;
    else if (step) begin
      if (at_lim)     cnt_d = '0;
      else if (user)  cnt_d = inc_usr;
      else            cnt_d = inc_sys;
    end
  end

  // limit next state
  always_comb begin
    lim_d = lim_q;
    if (mode_chg)      lim_d = '1;
    else if (ld_limit) lim_d = (lim_wr == '0) ? '1 : lim_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign cnt   = cnt_q;
  assign limit = lim_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_lim && !user) |=> cnt_q[LIM_W-1:0] == $past(cnt_q[LIM_W-1:0]) + 1'b1);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_lim) |=> cnt_q == '0);

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && run_en) && !restart) |=> $stable(cnt_q));

  p_limit_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lim_q != '0);
endmodule

// File: rtl/ptmr_status.sv
module ptmr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic user,
  input  logic mode_chg,
  input  logic hit,
  input  logic rd_clear,
  input  logic irq_clear,
  input  logic run_wr,
  input  logic run_val,
  output logic reached,
  output logic irq,
  output logic running
);
  logic reached_q, reached_d;
  logic irq_q, irq_d;
  logic run_q, run_d;

  always_comb begin
    reached_d = reached_q;
    if (hit)                        reached_d = 1'b1;
    else if (rd_clear || mode_chg)  reached_d = 1'b0;

    irq_d = irq_q;
    if (hit)                                    irq_d = 1'b1;
    else if (rd_clear || irq_clear || mode_chg) irq_d = 1'b0;

    run_d = run_q;
    if (mode_chg)    run_d = 1'b1;
    else if (run_wr) run_d = run_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
      run_q     <= 1'b1;
    end else begin
      reached_q <= reached_d;
      irq_q     <= irq_d;
      run_q     <= run_d;
    end
  end

  assign reached = reached_q;
  assign irq     = irq_q;
  assign running = run_q;

  p_irq_with_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> reached_q);

  p_hit_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (irq_q && reached_q));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !hit) |=> (!irq_q && !reached_q));

  p_user_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    user |-> (!irq_q && !reached_q));

  p_mode_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> run_q);
endmodule

// File: rtl/proc_limit_timer.sv
module proc_limit_timer
  import ptmr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              user_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic             srst_n;
  logic             mode_q, mode_d, mode_chg, restart;
  strobe_t          strobe;
  rsel_e            rsel;
  logic [USR_W-1:0] cnt;
  logic [LIM_W-1:0] limit;
  logic             hit, reached, running;
  logic             unused_wdata;

  assign unused_wdata = ^{bus_wdata[DATA_W-1], bus_wdata[UNIT_LSB-1:1]};

  ptmr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // registered mode; a difference marks a personality change
  always_comb begin
    mode_d   = user_mode;
    mode_chg = user_mode ^ mode_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) mode_q <= 1'b0;
    else         mode_q <= mode_d;
  end

  ptmr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .user     (mode_q),
    .strobe   (strobe),
    .rsel     (rsel)
  );

  assign restart = mode_chg | strobe.bus_restart;

  ptmr_counter u_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .tick     (tick),
    .run_en   (running),
    .user     (mode_q),
    .restart  (restart),
    .mode_chg (mode_chg),
    .ld_limit (strobe.ld_limit),
    .lim_wr   (bus_wdata[DATA_W-2:UNIT_LSB]),
    .cnt      (cnt),
    .limit    (limit),
    .hit      (hit)
  );

  ptmr_status u_st (
    .clk       (clk),
    .rst_n     (srst_n),
    .user      (mode_q),
    .mode_chg  (mode_chg),
    .hit       (hit),
    .rd_clear  (strobe.rd_clear),
    .irq_clear (strobe.bus_restart),
    .run_wr    (strobe.run_wr),
    .run_val   (bus_wdata[0]),
    .reached   (reached),
    .irq       (irq),
    .running   (running)
  );

  // read data
  always_comb begin
    unique case (rsel)
      RS_LIMIT:  bus_rdata = {1'b0, limit, {UNIT_LSB{1'b0}}};
      RS_SYSCNT: bus_rdata = {reached, cnt[LIM_W-1:0], {UNIT_LSB{1'b0}}};
      RS_USRHI:  bus_rdata = {{(DATA_W-HI_W){1'b0}}, cnt[USR_W-1:LO_W]};
      RS_USRLO:  bus_rdata = {cnt[LO_W-1:0], {UNIT_LSB{1'b0}}};
      RS_RUN:    bus_rdata = {{(DATA_W-1){1'b0}}, running};
      default:   bus_rdata = '0;
    endcase
  end

  p_idle_bus_zero_r11: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

// File: tb/sim_proc_limit_timer.sv
module sim_proc_limit_timer;
  logic        clk = 1'b0;
  logic        rst_n, tick, user_mode, bus_rd, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] v;
  localparam logic [31:0] MAXLIM = 32'h7FFF_FE00;

  proc_limit_timer #(.ADDR_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 3'(a); bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); user_mode = m;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; user_mode = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(0, v); chk("R1 limit", v, MAXLIM);
    rd(1, v); chk("R1 count", v, 32'h0);
    rd(3, v); chk("R1 running", v, 32'h1);

    // R2 counting unit
    ticks(5);
    rd(1, v); chk("R2 count", v, 32'd5 << 9);

    // R3 R4 R5 sweep over small limits
    for (int lim = 1; lim <= 8; lim++) begin
      wr(0, (32'(lim) << 9) | 32'h8000_01FF);
      for (int k = 1; k < lim; k++) begin
        ticks(1);
        chk("R3 no irq early", {31'b0, irq}, 32'h0);
      end
      ticks(1);
      chk("R3 irq at limit", {31'b0, irq}, 32'h1);
      rd(1, v); chk("R3 reached", v, 32'h8000_0000 | (32'(lim) << 9));
      ticks(1);
      rd(1, v); chk("R3 wrap", v, 32'h8000_0000);
      ticks(1);
      rd(1, v); chk("R3 continue", v, (lim == 1) ? 32'h8000_0200 : 32'h8000_0200);
      rd(0, v); chk("R4 limit read", v, 32'(lim) << 9);
      chk("R4 irq cleared", {31'b0, irq}, 32'h0);
      rd(1, v); chk("R4 flag cleared", v, 32'h0000_0200);
    end

    // R5 word 2 keeps count; word 0 write lowers irq only
    wr(0, 32'd10 << 9);
    ticks(3);
    wr(2, 32'd6 << 9);
    rd(1, v); chk("R5 no restart", v, 32'd3 << 9);
    ticks(2);
    chk("R5 before new limit", {31'b0, irq}, 32'h0);
    ticks(1);
    chk("R5 new limit hit", {31'b0, irq}, 32'h1);
    wr(0, 32'd5 << 9);
    chk("R5 write lowers irq", {31'b0, irq}, 32'h0);
    rd(1, v); chk("R5 flag kept", v, 32'h8000_0000);
    rd(0, v); chk("R5 limit", v, 32'd5 << 9);

    // R6 zero limit
    wr(0, 32'h0000_01FF);
    rd(0, v); chk("R6 word0 zero", v, MAXLIM);
    wr(2, 32'h8000_0000);
    rd(0, v); chk("R6 word2 zero", v, MAXLIM);

    // R4 hit wins over read clear
    wr(0, 32'd2 << 9);
    ticks(1);
    @(negedge clk); bus_addr = 3'd0; bus_rd = 1'b1; tick = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; tick = 1'b0;
    chk("R4 read data", v, 32'd2 << 9);
    chk("R4 hit wins irq", {31'b0, irq}, 32'h1);
    rd(1, v); chk("R4 hit wins flag", v, 32'h8000_0000 | (32'd2 << 9));
    rd(0, v);

    // R5 restart beats tick
    wr(0, 32'd20 << 9);
    ticks(4);
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 32'd20 << 9; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick = 1'b0;
    rd(1, v); chk("R5 restart vs tick", v, 32'h0);

    // R11 unlisted words, R9 run write ignored in limit mode
    ticks(3);
    rd(2, v); chk("R11 word2 read", v, 32'h0);
    for (int a = 4; a < 8; a++) begin
      rd(a, v); chk("R11 high read", v, 32'h0);
      wr(a, 32'hFFFF_FFFF);
    end
    wr(1, 32'hFFFF_FFFF);
    wr(3, 32'h0);
    rd(0, v); chk("R11 limit kept", v, 32'd20 << 9);
    rd(1, v); chk("R11 count kept", v, 32'd3 << 9);
    rd(3, v); chk("R9 limit-mode run write", v, 32'h1);
    ticks(1);
    rd(1, v); chk("R9 still running", v, 32'd4 << 9);

    // R10 mode change clears pending irq
    wr(0, 32'd1 << 9);
    ticks(1);
    chk("R10 irq before", {31'b0, irq}, 32'h1);
    set_mode(1'b1);
    chk("R10 irq cleared", {31'b0, irq}, 32'h0);
    rd(3, v); chk("R10 running", v, 32'h1);
    rd(1, v); chk("R10 count zero", v, 32'h0);
    rd(0, v); chk("R7 high word", v, 32'h0);

    // R7 user counting with no interrupt
    ticks(7);
    rd(1, v); chk("R7 low word", v, 32'd7 << 9);
    for (int i = 0; i < 300; i++) begin
      ticks(1);
      chk("R7 no irq", {31'b0, irq}, 32'h0);
    end
    rd(1, v); chk("R7 low word long", v, 32'd307 << 9);
    rd(0, v); chk("R7 high word long", v, 32'h0);

    // R8 user restarts
    wr(1, 32'h1234_5678);
    rd(1, v); chk("R8 word1 restart", v, 32'h0);
    ticks(2);
    wr(0, 32'h0);
    rd(1, v); chk("R8 word0 restart", v, 32'h0);

    // R11 word 2 write in user mode
    ticks(3);
    wr(2, 32'h0000_0200);
    rd(1, v); chk("R11 user word2", v, 32'd3 << 9);

    // R9 start/stop
    wr(3, 32'h0);
    rd(3, v); chk("R9 stopped", v, 32'h0);
    ticks(5);
    rd(1, v); chk("R9 frozen", v, 32'd3 << 9);
    wr(3, 32'h0);
    rd(3, v); chk("R9 stop again", v, 32'h0);
    wr(3, 32'h1);
    rd(3, v); chk("R9 started", v, 32'h1);
    ticks(2);
    rd(1, v); chk("R9 resumes", v, 32'd5 << 9);

    // R10 back to limit mode from a stopped counter
    wr(3, 32'h0);
    set_mode(1'b0);
    rd(3, v); chk("R10 run set", v, 32'h1);
    rd(1, v); chk("R10 count", v, 32'h0);
    rd(0, v); chk("R10 limit max", v, MAXLIM);
    chk("R10 irq", {31'b0, irq}, 32'h0);
    ticks(1);
    rd(1, v); chk("R10 counts", v, 32'd1 << 9);

    finish_run();
  end
endmodule